// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block walks a PLL through a safe change of its multiplier. On a start request it latches the packed multiplier word and the current control register contents. It then issues a fixed series of register writes on a simple write port. The first write powers the PLL down and takes it out of every bypass and direct path. Next come the new multiplier and a unity pre/post divider code. The last write of the series powers the PLL back up. After that it polls the lock flag at a fixed interval, paced by a one-microsecond tick, for a bounded number of samples. When lock is seen, the clock output is enabled and done is raised. When lock never appears, error is raised instead.

A request flagged as needing a divide below the input rate is refused straight away and issues no write. Bits of the control register outside the five managed ones keep their latched values in every control write.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, err_o and wr_en_o are all low.
- R2: The first write after an accepted start goes to address 0x20 (control). Its data is the latched control value with bit 0 (power-down) set and bits 1 to 4 (bypass, direct-in, direct-out, output enable) cleared. All other bits are unchanged.
- R3: The second write puts the latched multiplier word at address 0x24. The third write puts 0x00302062 (unity pre and post divide) at address 0x28.
- R4: The fourth write goes to address 0x20 with bits 0 to 4 all clear and the other bits preserved. The four writes fall on four consecutive cycles, starting the cycle after start is taken.
- R5: After the fourth write, bit 0 of stat_i (lock) is sampled once every WAIT_US ticks of tick_us_i, for at most POLLS samples (defaults 10 and 4).
- R6: On the first sample that shows lock, one further write goes to address 0x20 with bit 4 set and bits 0 to 3 clear. done_o then rises and busy_o falls.
- R7: If none of the POLLS samples shows lock, err_o rises, busy_o falls and no output-enable write is made.
- R8: A start with need_div_i high is refused: err_o is set, done_o is cleared and no write is issued.
- R9: Start requests while busy_o is high are ignored. They change neither the write sequence nor the result.
- R10: done_o and err_o are never high together, and each holds until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a reprogramming sequence |
| need_div_i | input | 1 | Request would need a divide below the input rate; refuse it |
| mult_i | input | DW | Packed multiplier word, latched at start |
| ctl_init_i | input | DW | Current control register contents, latched at start |
| stat_i | input | DW | PLL status word; bit 0 is lock |
| tick_us_i | input | 1 | One-cycle pulse every microsecond |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | AW | Register write address |
| wr_data_o | output | DW | Register write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last sequence ended with lock |
| err_o | output | 1 | Last sequence failed or was refused |

## Verification
Two events can land in the same cycle: the final permitted lock sample and the arrival of lock. The bench sweeps the lock arrival across each sample slot and past the last one. It then expects success with exactly 10·(k+1) ticks consumed when lock arrives by sample k, and error after 40 ticks when it does not. A second collision is a new start pulse in the cycle of the output-enable write, or in the middle of polling. The bench checks that the write log, the tick count and the held done flag are all unaffected.

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int WAIT_US = 10,
  parameter int POLLS = 4,
  parameter logic [7:0] CTRL_ADDR = 8'h20,
  parameter logic [7:0] MUL_ADDR = 8'h24,
  parameter logic [7:0] DIV_ADDR = 8'h28,
  parameter logic [31:0] DIV_UNITY = 32'h0030_2062
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          need_div_i,
  input  logic [DW-1:0] mult_i,
  input  logic [DW-1:0] ctl_init_i,
  input  logic [DW-1:0] stat_i,
  input  logic          tick_us_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int TW = $clog2(WAIT_US + 1);
  localparam int PW = $clog2(POLLS + 1);
  localparam logic [DW-1:0] PD_M = DW'(1);
  localparam logic [DW-1:0] EN_M = DW'(16);
  localparam logic [DW-1:0] MGD_M = DW'(31);

  typedef enum logic [2:0] {S_IDLE, S_PD, S_MUL, S_DIV, S_PU, S_WAIT, S_EN} st_t;

  st_t            st;
  logic [DW-1:0]  shadow, mult_q;
  logic [TW-1:0]  tcnt;
  logic [PW-1:0]  pcnt;

  assign busy_o = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; shadow <= '0; mult_q <= '0;
      tcnt <= '0; pcnt <= '0; done_o <= 1'b0; err_o <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          done_o <= 1'b0;
          if (need_div_i) err_o <= 1'b1;
          else begin
            err_o  <= 1'b0;
            shadow <= (ctl_init_i & ~MGD_M) | PD_M;
            mult_q <= mult_i;
            st     <= S_PD;
          end
        end
        S_PD:  st <= S_MUL;
        S_MUL: st <= S_DIV;
        S_DIV: st <= S_PU;
        S_PU: begin
          shadow <= shadow & ~PD_M;
          tcnt <= '0; pcnt <= '0;
          st <= S_WAIT;
        end
        S_WAIT: if (tick_us_i) begin
          if (tcnt == TW'(WAIT_US - 1)) begin
            tcnt <= '0;
            if (stat_i[0]) st <= S_EN;
            else if (pcnt == PW'(POLLS - 1)) begin
              st <= S_IDLE; err_o <= 1'b1;
            end else pcnt <= pcnt + 1'b1;
          end else tcnt <= tcnt + 1'b1;
        end
        S_EN: begin st <= S_IDLE; done_o <= 1'b1; end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en_o = 1'b1; wr_addr_o = AW'(CTRL_ADDR); wr_data_o = shadow;
    case (st)
      S_PD:  ;
      S_MUL: begin wr_addr_o = AW'(MUL_ADDR); wr_data_o = mult_q; end
      S_DIV: begin wr_addr_o = AW'(DIV_ADDR); wr_data_o = DW'(DIV_UNITY); end
      S_PU:  wr_data_o = shadow & ~PD_M;
      S_EN:  wr_data_o = shadow | EN_M;
      default: begin wr_en_o = 1'b0; wr_data_o = '0; end
    endcase
  end

  a_r2_pd_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (wr_en_o && wr_addr_o == AW'(CTRL_ADDR) && wr_data_o[0] && wr_data_o[4:1] == 4'b0));
  a_r6_en_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_addr_o == AW'(CTRL_ADDR) && wr_data_o[4]) |-> $past(tick_us_i && stat_i[0]));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !wr_en_o);
  a_r10_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
  a_r5_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt < PW'(POLLS));
  a_r10_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);
endmodule

// File: tb/pll_reprog_seq_tb.sv
module pll_reprog_seq_tb;
  logic clk = 0, rst_n = 0, start_i = 0, need_div_i = 0, tick_us_i = 0;
  logic [31:0] mult_i = 0, ctl_init_i = 0, stat_i = 0;
  logic wr_en_o, busy_o, done_o, err_o;
  logic [7:0] wr_addr_o;
  logic [31:0] wr_data_o;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  pll_reprog_seq u_dut (.clk, .rst_n, .start_i, .need_div_i, .mult_i, .ctl_init_i,
    .stat_i, .tick_us_i, .wr_en_o, .wr_addr_o, .wr_data_o, .busy_o, .done_o, .err_o);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] init, input logic [31:0] mult, input int lock_at, input bit poke);
    logic [7:0] wa[8]; logic [31:0] wd[8];
    int nw = 0, tcount = 0, cyc = 0, first_cyc = -1;
    bit pend = 0, in_wait = 0;
    int k = (lock_at < 4) ? lock_at : 3;
    bit ok = (lock_at < 4);
    logic [31:0] keep = init & ~32'h1F;
    ctl_init_i = init; mult_i = mult; need_div_i = 0; stat_i = 0;
    start_i = 1; @(negedge clk); start_i = 0;
    ctl_init_i = 32'hDEAD_BEEF; mult_i = 32'h1234_5678;
    while (busy_o && cyc < 3000) begin
      start_i = 0;
      if (wr_en_o) begin
        if (nw < 8) begin wa[nw] = wr_addr_o; wd[nw] = wr_data_o; end
        if (nw == 0) first_cyc = cyc;
        nw++;
        if (nw == 4) pend = 1;
        if (nw == 5 && poke) start_i = 1;
      end else if (pend) begin in_wait = 1; pend = 0; end
      stat_i[0] = (tcount >= 10 * lock_at + 5);
      tick_us_i = in_wait && busy_o && nw < 5 && (cyc % 3 == 0);
      if (tick_us_i) tcount++;
      if (poke && tcount == 7 && tick_us_i) start_i = 1;
      cyc++;
      @(negedge clk);
    end
    start_i = 0; tick_us_i = 0;
    chk("R4 first write cycle", first_cyc, 0);
    chk("R6/R7 write count", nw, ok ? 5 : 4);
    chk("R2 pd addr", {24'h0, wa[0]}, 32'h20);
    chk("R2 pd data", wd[0], keep | 32'h1);
    chk("R3 mul addr", {24'h0, wa[1]}, 32'h24);
    chk("R3 mul data", wd[1], mult);
    chk("R3 div addr", {24'h0, wa[2]}, 32'h28);
    chk("R3 div data", wd[2], 32'h0030_2062);
    chk("R4 pu addr", {24'h0, wa[3]}, 32'h20);
    chk("R4 pu data", wd[3], keep);
    if (ok) begin
      chk("R6 en addr", {24'h0, wa[4]}, 32'h20);
      chk("R6 en data", wd[4], keep | 32'h10);
    end
    chk("R5 ticks used", tcount, 10 * (k + 1));
    chk("R6 done", done_o, ok);
    chk("R7 err", err_o, !ok);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 idle no write", wr_en_o, 0);
      chk("R10 flags held", {done_o, err_o}, {ok, !ok});
    end
  endtask

  initial begin
    automatic logic [31:0] inits[4] = '{32'h0, 32'hFFFF_FFFF, 32'hA5A5_00E6, 32'h0000_001F};
    repeat (3) @(negedge clk);
    chk("R1 busy", busy_o, 0); chk("R1 done", done_o, 0);
    chk("R1 err", err_o, 0); chk("R1 wr", wr_en_o, 0);
    rst_n = 1; @(negedge clk);
    for (int i = 0; i < 4; i++)
      for (int l = 0; l < 6; l++)
        run(inits[i], 32'h0001_0000 * i + 32'h0345 * l + 32'h7, l, (l % 2) == 0);
    need_div_i = 1; start_i = 1; @(negedge clk); start_i = 0; need_div_i = 0;
    for (int i = 0; i < 4; i++) begin
      chk("R8 no write", wr_en_o, 0); chk("R8 busy", busy_o, 0);
      chk("R8 err", err_o, 1); chk("R10 done clr", done_o, 0);
      @(negedge clk);
    end
    run(32'h1234_0000, 32'h0000_4000, 1, 1);
    chk("R10 err cleared by start", err_o, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #20ms;
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule